// File: doc/BRIEF.md
# Rotating-Parity Stripe Address Mapper

This block turns a logical block number into a physical placement inside a disk array that spreads its parity across every column. Each stripe (row) carries one parity block and `DISKS-1` data blocks. The parity column moves one disk lower on every new stripe and wraps back to the highest disk after it reaches disk 0. Data blocks fill the columns that are not parity, in ascending disk order. Logical numbering runs across a stripe first and then steps to the next stripe.

A request strobe with a block number gives a registered result one clock later: the stripe number, the disk that holds the data block, and the parity disk of that stripe. A second, independent query port takes a stripe number on its own and returns that stripe's parity disk, also one clock later. An array controller can use the query port to find the parity column during a read-modify-write, without sending a dummy block number. The disk count and the address width are parameters. The default is five disks and 16-bit addresses.

Top module: `raid5_stripe_mapper`

## Requirements
- R1: After reset, `map_valid` and `qry_ack` are 0.
- R2: `map_valid` is high exactly in the cycle after a cycle in which `req_valid` was high, so the latency is one clock.
- R3: `map_stripe` equals the requested block number divided by `DISKS-1`, using integer division.
- R4: `map_parity` equals `(DISKS-1) - (stripe mod DISKS)`. With five disks, stripes 0,1,2,3,4 use parity disks 4,3,2,1,0, and stripe 5 uses disk 4 again.
- R5: With offset = block number mod `DISKS-1`, `map_disk` is the offset when the offset is below the parity disk, and offset+1 otherwise. With five disks, blocks 4,5,6,7 land on disks 0,1,2,4.
- R6: When `map_valid` is high, `map_disk` differs from `map_parity`, and both are below `DISKS`.
- R7: `qry_ack` is high exactly in the cycle after `qry_valid` was high, and `qry_parity` then follows the rule of R4 for `qry_stripe`.
- R8: While `req_valid` is low, a change of `req_lbn` has no effect: `map_stripe`, `map_disk` and `map_parity` keep their previous values.

Ports are listed in the order of the port list of `raid5_stripe_mapper`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe for a block mapping |
| req_lbn | input | ADDR_W | Logical block number |
| map_valid | output | 1 | Mapping result valid |
| map_stripe | output | ADDR_W | Stripe (row) number |
| map_disk | output | DISK_W | Disk that holds the data block |
| map_parity | output | DISK_W | Parity disk of the stripe |
| qry_valid | input | 1 | Stripe query strobe |
| qry_stripe | input | ADDR_W | Stripe number to query |
| qry_ack | output | 1 | Query result valid |
| qry_parity | output | DISK_W | Parity disk of the queried stripe |

## Verification
There is no state across requests apart from the result registers. A wrong divide, modulo or skip decision therefore shows at the ports in the very next cycle, on the one block that triggers it. The faults most likely to hide are off-by-one errors at the stripe boundary and errors in the skip over the parity column. To catch them, the bench covers the first and last block of a stripe, the column right after parity, the wrap from disk 0 back to the top disk, and the largest address. If a hold-enable is wrong, a stale or overwritten result appears on the first idle cycle after a request.

// File: rtl/raid5_map_pkg.sv
package raid5_map_pkg;
    localparam int unsigned MIN_DISKS = 3;

    function automatic int unsigned disk_bits(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/stripe_split.sv
module stripe_split #(
    parameter int unsigned DISKS  = 5,
    parameter int unsigned ADDR_W = 16,
    localparam int unsigned DISK_W = raid5_map_pkg::disk_bits(DISKS)
) (
    input  logic [ADDR_W-1:0] lbn,
    output logic [ADDR_W-1:0] stripe,
    output logic [DISK_W-1:0] offset
);
    localparam logic [ADDR_W-1:0] DATA_COLS = ADDR_W'(DISKS - 1);

    always_comb begin
        stripe = lbn / DATA_COLS;
        offset = DISK_W'(lbn % DATA_COLS);
    end
endmodule

// File: rtl/parity_rotor.sv
module parity_rotor #(
    parameter int unsigned DISKS  = 5,
    parameter int unsigned ADDR_W = 16,
    localparam int unsigned DISK_W = raid5_map_pkg::disk_bits(DISKS)
) (
    input  logic [ADDR_W-1:0] stripe,
    output logic [DISK_W-1:0] parity
);
    localparam logic [ADDR_W-1:0] NDISK = ADDR_W'(DISKS);
    localparam logic [ADDR_W-1:0] TOP   = ADDR_W'(DISKS - 1);

    logic [ADDR_W-1:0] phase;

    always_comb begin
        phase  = stripe % NDISK;
        parity = DISK_W'(TOP - phase);
    end
endmodule

// File: rtl/column_place.sv
module column_place #(
    parameter int unsigned DISKS = 5,
    localparam int unsigned DISK_W = raid5_map_pkg::disk_bits(DISKS)
) (
    input  logic [DISK_W-1:0] offset,
    input  logic [DISK_W-1:0] parity,
    output logic [DISK_W-1:0] disk
);
    always_comb begin
        if (offset < parity) disk = offset;
        else                 disk = offset + DISK_W'(1);
    end
endmodule

// File: rtl/raid5_stripe_mapper.sv
module raid5_stripe_mapper #(
    parameter int unsigned DISKS  = 5,
    parameter int unsigned ADDR_W = 16,
    localparam int unsigned DISK_W = raid5_map_pkg::disk_bits(DISKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_lbn,
    output logic              map_valid,
    output logic [ADDR_W-1:0] map_stripe,
    output logic [DISK_W-1:0] map_disk,
    output logic [DISK_W-1:0] map_parity,
    input  logic              qry_valid,
    input  logic [ADDR_W-1:0] qry_stripe,
    output logic              qry_ack,
    output logic [DISK_W-1:0] qry_parity
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] stripe;
        logic [DISK_W-1:0] disk;
        logic [DISK_W-1:0] parity;
        logic              qack;
        logic [DISK_W-1:0] qpar;
    } map_state_t;

    map_state_t st_d, st_q;

    logic [ADDR_W-1:0] split_stripe;
    logic [DISK_W-1:0] split_offset;
    logic [DISK_W-1:0] req_parity;
    logic [DISK_W-1:0] req_disk;
    logic [DISK_W-1:0] q_parity;

    initial assert (DISKS >= raid5_map_pkg::MIN_DISKS);

    stripe_split #(.DISKS(DISKS), .ADDR_W(ADDR_W)) u_split (
        .lbn    (req_lbn),
        .stripe (split_stripe),
        .offset (split_offset)
    );

    parity_rotor #(.DISKS(DISKS), .ADDR_W(ADDR_W)) u_rot_req (
        .stripe (split_stripe),
        .parity (req_parity)
    );

    parity_rotor #(.DISKS(DISKS), .ADDR_W(ADDR_W)) u_rot_qry (
        .stripe (qry_stripe),
        .parity (q_parity)
    );

    column_place #(.DISKS(DISKS)) u_place (
        .offset (split_offset),
        .parity (req_parity),
        .disk   (req_disk)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = req_valid;
        st_d.qack = qry_valid;
        if (req_valid) begin
            st_d.stripe = split_stripe;
            st_d.disk   = req_disk;
            st_d.parity = req_parity;
        end
        if (qry_valid) begin
            st_d.qpar = q_parity;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign map_valid  = st_q.vld;
    assign map_stripe = st_q.stripe;
    assign map_disk   = st_q.disk;
    assign map_parity = st_q.parity;
    assign qry_ack    = st_q.qack;
    assign qry_parity = st_q.qpar;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> map_valid); // R2
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !map_valid); // R2
    AST_PARITY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        map_valid |-> (map_parity < DISK_W'(DISKS))); // R4
    AST_DISJOINT_COLS: assert property (@(posedge clk) disable iff (!rst_n)
        map_valid |-> (map_disk != map_parity && map_disk < DISK_W'(DISKS))); // R6
    AST_QRY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        qry_valid |=> qry_ack); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(map_stripe) && $stable(map_disk) && $stable(map_parity))); // R8
endmodule

// File: tb/raid5_stripe_mapper_test.sv
module raid5_stripe_mapper_test;
    localparam int unsigned DISKS  = 5;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned DISK_W = 3;
    localparam time PERIOD = 10ns;
    localparam int NVEC = 13;

    // fields: lbn[39:24] stripe[23:8] disk[7:4] parity[3:0]
    localparam logic [39:0] VEC [NVEC] = '{
        {16'd0,     16'd0,     4'd0, 4'd4},
        {16'd3,     16'd0,     4'd3, 4'd4},
        {16'd4,     16'd1,     4'd0, 4'd3},
        {16'd6,     16'd1,     4'd2, 4'd3},
        {16'd7,     16'd1,     4'd4, 4'd3},
        {16'd9,     16'd2,     4'd1, 4'd2},
        {16'd10,    16'd2,     4'd3, 4'd2},
        {16'd12,    16'd3,     4'd0, 4'd1},
        {16'd13,    16'd3,     4'd2, 4'd1},
        {16'd16,    16'd4,     4'd1, 4'd0},
        {16'd19,    16'd4,     4'd4, 4'd0},
        {16'd20,    16'd5,     4'd0, 4'd4},
        {16'd65535, 16'd16383, 4'd4, 4'd1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_lbn = '0;
    logic              map_valid;
    logic [ADDR_W-1:0] map_stripe;
    logic [DISK_W-1:0] map_disk;
    logic [DISK_W-1:0] map_parity;
    logic              qry_valid = 1'b0;
    logic [ADDR_W-1:0] qry_stripe = '0;
    logic              qry_ack;
    logic [DISK_W-1:0] qry_parity;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    raid5_stripe_mapper #(.DISKS(DISKS), .ADDR_W(ADDR_W)) uut (
        .clk, .rst_n, .req_valid, .req_lbn, .map_valid, .map_stripe,
        .map_disk, .map_parity, .qry_valid, .qry_stripe, .qry_ack, .qry_parity
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic map_one(input logic [ADDR_W-1:0] lbn, output logic [ADDR_W-1:0] s,
                           output logic [DISK_W-1:0] d, output logic [DISK_W-1:0] p,
                           output logic v);
        @(negedge clk);
        req_valid = 1'b1;
        req_lbn   = lbn;
        @(negedge clk);
        req_valid = 1'b0;
        v = map_valid; s = map_stripe; d = map_disk; p = map_parity;
    endtask

    initial begin
        logic [ADDR_W-1:0] s;
        logic [DISK_W-1:0] d, p;
        logic v;
        repeat (3) @(negedge clk);
        chk(map_valid == 1'b0, "R1 map_valid", map_valid, 0);
        chk(qry_ack == 1'b0, "R1 qry_ack", qry_ack, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(map_valid == 1'b0, "R1 idle after reset", map_valid, 0);

        for (int i = 0; i < NVEC; i++) begin
            map_one(VEC[i][39:24], s, d, p, v);
            chk(v == 1'b1, "R2 valid", v, 1);
            chk(s == VEC[i][23:8], "R3 stripe", s, VEC[i][23:8]);
            chk(p == VEC[i][2:0], "R4 parity", p, VEC[i][2:0]);
            chk(d == VEC[i][6:4], "R5 disk", d, VEC[i][6:4]);
        end

        // sweep: expected from the stated rules
        for (int n = 0; n < 60; n++) begin
            int es, eo, ep, ed;
            es = n / (DISKS - 1);
            eo = n % (DISKS - 1);
            ep = (DISKS - 1) - (es % DISKS);
            ed = (eo < ep) ? eo : eo + 1;
            map_one(ADDR_W'(n), s, d, p, v);
            chk(s == ADDR_W'(es), "R3 sweep stripe", s, es);
            chk(p == DISK_W'(ep), "R4 sweep parity", p, ep);
            chk(d == DISK_W'(ed), "R5 sweep disk", d, ed);
            chk(d != p, "R6 disjoint", d, p);
        end

        // R2: valid drops one cycle after strobe ends
        @(negedge clk);
        chk(map_valid == 1'b0, "R2 valid drop", map_valid, 0);

        // R8: idle input change ignored
        map_one(16'd7, s, d, p, v);
        req_lbn = 16'd16;
        @(negedge clk);
        req_lbn = 16'd3;
        @(negedge clk);
        chk(map_disk == 3'd4, "R8 disk held", map_disk, 4);
        chk(map_parity == 3'd3, "R8 parity held", map_parity, 3);
        chk(map_stripe == 16'd1, "R8 stripe held", map_stripe, 1);

        // R7: query port
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            qry_valid  = 1'b1;
            qry_stripe = ADDR_W'(k);
            @(negedge clk);
            qry_valid = 1'b0;
            chk(qry_ack == 1'b1, "R7 ack", qry_ack, 1);
            chk(qry_parity == DISK_W'((DISKS - 1) - (k % DISKS)), "R7 parity",
                qry_parity, (DISKS - 1) - (k % DISKS));
        end
        @(negedge clk);
        chk(qry_ack == 1'b0, "R7 ack drop", qry_ack, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule